// File: doc/BRIEF.md
# Wait-for-Interrupt Wake Controller

This block holds a processor core stalled once the pipeline signals that a wait-for-interrupt request has begun, and decides when and how to let the core go. It watches the two active-low interrupt lines, the fast-interrupt and normal-interrupt mask bits from the status register, a debug request and a debug-enable input. Whether the core wakes is decided apart from interrupt masking, so a masked interrupt still ends the wait. A debug request ends the wait only while debugging is enabled.

When the wait ends, the block releases the stall and raises one of three one-cycle indications for the pipeline. The first tells it to enter the interrupt handler before the next instruction. The second tells it to enter debug state before any further instruction. The third tells it to resume at the instruction after the wait. The interrupt lines are level-sensitive and pass through a two-flop synchroniser before they are evaluated. The debug inputs and the mask bits are taken as already synchronous to the clock.

Top module: `wfiWakeCtrl`

## Requirements
- R1: After reset, `coreStall`, `wakeTakeIrq`, `wakeEnterDbg` and `wakeResume` are all 0.
- R2: When `wfiEnter` is sampled high at a clock edge while the core is not stalled, `coreStall` is 1 from that edge on.
- R3: While stalled, an interrupt line held low (`fiqN` or `irqN`) ends the stall whatever the values of `maskF` and `maskI`.
- R4: While stalled, `dbgReq` ends the stall only if `dbgEn` is 1 at the same edge. With `dbgEn` at 0, the stall stays on however long `dbgReq` is held.
- R5: A wake with an unmasked interrupt active (`fiqN` low with `maskF` 0, or `irqN` low with `maskI` 0), and no enabled debug request, pulses `wakeTakeIrq`.
- R6: A wake caused only by masked interrupts pulses `wakeResume`, and `wakeTakeIrq` stays 0.
- R7: A wake with an enabled debug request pulses `wakeEnterDbg`, even if an unmasked interrupt is active in the same cycle. `wakeTakeIrq` stays 0, and the interrupt, still held low, is taken at the next wait.
- R8: Exactly one indication is 1 in the single cycle in which `coreStall` falls. In every other cycle all three indications are 0.
- R9: An interrupt pin driven low just after edge t is seen through two synchroniser flops, so `coreStall` is still 1 after edges t+1 and t+2 and is 0 after edge t+3. A debug wake acts at the first edge.
- R10: `wfiEnter` sampled while already stalled has no effect. After the next wake, the stall stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fiqN | input | 1 | Fast interrupt line, active low, asynchronous |
| irqN | input | 1 | Normal interrupt line, active low, asynchronous |
| maskF | input | 1 | Fast interrupt mask bit (1 = masked) |
| maskI | input | 1 | Normal interrupt mask bit (1 = masked) |
| dbgReq | input | 1 | Debug request |
| dbgEn | input | 1 | Debug enable; qualifies dbgReq as a wake source |
| wfiEnter | input | 1 | One-cycle strobe that starts the wait |
| coreStall | output | 1 | Holds the core while high |
| wakeTakeIrq | output | 1 | Pulse: take the interrupt before the next instruction |
| wakeEnterDbg | output | 1 | Pulse: enter debug state before any instruction |
| wakeResume | output | 1 | Pulse: resume at the next instruction |

## Verification
The hardest case to reach from the ports is an unmasked interrupt and an enabled debug request landing at the same edge. The interrupt reaches the decision two edges after its pin, while the debug request acts at once. The stimulus therefore drops the interrupt pin and raises the debug request exactly two cycles later. It then keeps the interrupt line low into a fresh wait, which shows that the interrupt was left pending and is taken at once. A cycle-by-cycle behavioural model in the bench is compared against all four outputs on every clock.

// File: rtl/wfi_pkg.sv
package wfi_pkg;

  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } wfiState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armed;       // core is held; wake evaluation enabled
    logic latchCause;  // wake accepted this cycle; record cause
  } ctrlStrobe_t;

  // cause encoding carried by the datapath register
  localparam int CAUSE_W   = 3;
  localparam int CAUSE_IRQ = 0;
  localparam int CAUSE_DBG = 1;
  localparam int CAUSE_RES = 2;

endpackage

// File: rtl/wfiWakePath.sv
module wfiWakePath
  import wfi_pkg::*;
#(
  parameter int NUM_LINES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] intN,
  input  logic [NUM_LINES-1:0] intMask,
  input  logic                 dbgReq,
  input  logic                 dbgEn,
  input  ctrlStrobe_t          strobe,
  output logic                 wakeEv,
  output logic                 takeIrq,
  output logic                 enterDbg,
  output logic                 resumeNext
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_LINES-1:0] lineActive;
  logic                 intAny;
  logic                 intLive;
  logic                 dbgOk;
  logic [CAUSE_W-1:0]   causeQ;
  logic [CAUSE_W-1:0]   causeD;

  // per-line synchroniser; active-high internally
  for (genvar g = 0; g < NUM_LINES; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[LAST-1:0], ~intN[g]};
    end
    assign lineActive[g] = chain[LAST];
  end

  // wake qualification is independent of masking
  assign intAny  = |lineActive;
  assign intLive = |(lineActive & ~intMask);
  assign dbgOk   = dbgReq & dbgEn;
  assign wakeEv  = strobe.armed & (intAny | dbgOk);

  // priority: debug, then unmasked interrupt, then plain resume
  always_comb begin
    causeD = '0;
    if (strobe.latchCause) begin
      if (dbgOk)        causeD[CAUSE_DBG] = 1'b1;
      else if (intLive) causeD[CAUSE_IRQ] = 1'b1;
      else              causeD[CAUSE_RES] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) causeQ <= '0;
    else       causeQ <= causeD;
  end

  assign takeIrq    = causeQ[CAUSE_IRQ];
  assign enterDbg   = causeQ[CAUSE_DBG];
  assign resumeNext = causeQ[CAUSE_RES];

  AST_DBG_PRIO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchCause && dbgOk) |=> (enterDbg && !takeIrq)); // R7

  AST_MASKED_RESUME: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchCause && !dbgOk && !intLive) |=> (resumeNext && !takeIrq)); // R6

  AST_LIVE_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchCause && !dbgOk && intLive) |=> takeIrq); // R5

  AST_NO_DBG_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.armed && !dbgEn && !intAny) |-> !wakeEv); // R4

endmodule

// File: rtl/wfiCtrlFsm.sv
module wfiCtrlFsm
  import wfi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wfiEnter,
  input  logic        wakeEv,
  output ctrlStrobe_t strobe,
  output logic        coreStall
);

  wfiState_t stateQ;
  wfiState_t stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_RUN:  if (wfiEnter) stateD = ST_WAIT;
      ST_WAIT: if (wakeEv)   stateD = ST_RUN;
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  assign strobe.armed      = (stateQ == ST_WAIT);
  assign strobe.latchCause = (stateQ == ST_WAIT) && wakeEv;
  assign coreStall         = (stateQ == ST_WAIT);

  AST_STALL_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (!coreStall && wfiEnter) |=> coreStall); // R2

  AST_HOLD_NO_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (coreStall && !wakeEv) |=> coreStall); // R10

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (coreStall && wakeEv) |=> !coreStall); // R3

endmodule

// File: rtl/wfiWakeCtrl.sv
module wfiWakeCtrl
  import wfi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic fiqN,
  input  logic irqN,
  input  logic maskF,
  input  logic maskI,
  input  logic dbgReq,
  input  logic dbgEn,
  input  logic wfiEnter,
  output logic coreStall,
  output logic wakeTakeIrq,
  output logic wakeEnterDbg,
  output logic wakeResume
);

  localparam int NUM_LINES = 2;

  ctrlStrobe_t strobe;
  logic        wakeEv;

  wfiWakePath #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .intN      ({fiqN, irqN}),
    .intMask   ({maskF, maskI}),
    .dbgReq    (dbgReq),
    .dbgEn     (dbgEn),
    .strobe    (strobe),
    .wakeEv    (wakeEv),
    .takeIrq   (wakeTakeIrq),
    .enterDbg  (wakeEnterDbg),
    .resumeNext(wakeResume)
  );

  wfiCtrlFsm u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wfiEnter (wfiEnter),
    .wakeEv   (wakeEv),
    .strobe   (strobe),
    .coreStall(coreStall)
  );

  AST_ONE_CAUSE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreStall) |-> ($countones({wakeTakeIrq, wakeEnterDbg, wakeResume}) == 1)); // R8

  AST_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(coreStall) |-> !(wakeTakeIrq || wakeEnterDbg || wakeResume)); // R8

endmodule

// File: tb/wfiWakeCtrl_tb.sv
module wfiWakeCtrl_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fiqN = 1'b1, irqN = 1'b1, maskF = 1'b0, maskI = 1'b0;
  logic dbgReq = 1'b0, dbgEn = 1'b0, wfiEnter = 1'b0;
  logic coreStall, wakeTakeIrq, wakeEnterDbg, wakeResume;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wfiWakeCtrl u_dut (
    .clk(clk), .rstN(rstN), .fiqN(fiqN), .irqN(irqN),
    .maskF(maskF), .maskI(maskI), .dbgReq(dbgReq), .dbgEn(dbgEn),
    .wfiEnter(wfiEnter), .coreStall(coreStall), .wakeTakeIrq(wakeTakeIrq),
    .wakeEnterDbg(wakeEnterDbg), .wakeResume(wakeResume)
  );

  // behavioural model: bit queues stand in for the two-cycle pin delay
  bit fiqHist[$] = '{0, 0};
  bit irqHist[$] = '{0, 0};
  bit mWait = 0, mIrq = 0, mDbg = 0, mRes = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fiqHist = '{0, 0}; irqHist = '{0, 0};
      mWait = 0; mIrq = 0; mDbg = 0; mRes = 0;
    end else begin
      bit fSeen, iSeen, wake, dbgOk, live;
      fSeen = fiqHist[0]; iSeen = irqHist[0];
      dbgOk = dbgReq && dbgEn;
      live  = (fSeen && !maskF) || (iSeen && !maskI);
      wake  = mWait && (fSeen || iSeen || dbgOk);
      mIrq = 0; mDbg = 0; mRes = 0;
      if (wake) begin
        if (dbgOk) mDbg = 1;
        else if (live) mIrq = 1;
        else mRes = 1;
        mWait = 0;
      end else if (!mWait && wfiEnter) begin
        mWait = 1;
      end
      void'(fiqHist.pop_front()); fiqHist.push_back(!fiqN);
      void'(irqHist.pop_front()); irqHist.push_back(!irqN);
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 R3 R4 R9 R10 model coreStall", coreStall, mWait);
      chk("R5 R8 model wakeTakeIrq", wakeTakeIrq, mIrq);
      chk("R7 R8 model wakeEnterDbg", wakeEnterDbg, mDbg);
      chk("R6 R8 model wakeResume", wakeResume, mRes);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enterWfi();
    wfiEnter = 1'b1; cyc(1); wfiEnter = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      finishRun();
    end
  end

  initial begin
    cyc(3);
    chk("R1 reset coreStall", coreStall, 1'b0);
    chk("R1 reset wakeTakeIrq", wakeTakeIrq, 1'b0);
    chk("R1 reset wakeEnterDbg", wakeEnterDbg, 1'b0);
    chk("R1 reset wakeResume", wakeResume, 1'b0);
    rstN = 1'b1;
    cyc(2);

    // R2, R4: enter, then debug request with debug disabled
    enterWfi();
    chk("R2 stall after entry", coreStall, 1'b1);
    dbgReq = 1'b1; dbgEn = 1'b0;
    cyc(6);
    chk("R4 disabled debug ignored", coreStall, 1'b1);
    dbgReq = 1'b0;

    // R3, R6, R9: masked fast interrupt wakes, resume
    maskF = 1'b1; fiqN = 1'b0;
    cyc(2);
    chk("R9 stall held through sync", coreStall, 1'b1);
    cyc(1);
    chk("R3 R9 masked fiq releases", coreStall, 1'b0);
    chk("R6 resume on masked wake", wakeResume, 1'b1);
    chk("R6 no take on masked wake", wakeTakeIrq, 1'b0);
    cyc(1);
    chk("R8 pulse lasts one cycle", wakeResume, 1'b0);
    fiqN = 1'b1; maskF = 1'b0;
    cyc(4);

    // R5, R10: unmasked normal interrupt; extra entry strobe while stalled
    enterWfi();
    cyc(2);
    enterWfi();
    chk("R10 re-entry keeps stall", coreStall, 1'b1);
    irqN = 1'b0;
    cyc(3);
    chk("R5 unmasked irq releases", coreStall, 1'b0);
    chk("R5 take irq", wakeTakeIrq, 1'b1);
    cyc(2);
    chk("R10 no re-entry after wake", coreStall, 1'b0);
    irqN = 1'b1;
    cyc(4);

    // R7, R9: enabled debug wakes at the first edge
    enterWfi();
    dbgEn = 1'b1; dbgReq = 1'b1;
    cyc(1);
    chk("R9 R7 debug immediate release", coreStall, 1'b0);
    chk("R7 enter debug", wakeEnterDbg, 1'b1);
    dbgReq = 1'b0;
    cyc(3);

    // R7: unmasked irq and enabled debug at the same edge
    enterWfi();
    maskI = 1'b0; irqN = 1'b0;
    cyc(2);
    dbgReq = 1'b1;
    cyc(1);
    chk("R7 simultaneous release", coreStall, 1'b0);
    chk("R7 debug wins", wakeEnterDbg, 1'b1);
    chk("R7 irq not taken", wakeTakeIrq, 1'b0);
    dbgReq = 1'b0;
    cyc(2);
    // interrupt still low: next wait ends at once with the interrupt taken
    enterWfi();
    chk("R2 stall on pending entry", coreStall, 1'b1);
    cyc(1);
    chk("R7 pending irq taken", wakeTakeIrq, 1'b1);
    irqN = 1'b1;
    cyc(4);

    // R3: both lines masked together
    maskF = 1'b1; maskI = 1'b1;
    enterWfi();
    fiqN = 1'b0; irqN = 1'b0;
    cyc(3);
    chk("R3 both masked release", coreStall, 1'b0);
    chk("R6 both masked resume", wakeResume, 1'b1);
    fiqN = 1'b1; irqN = 1'b1;
    cyc(4);

    // R1: reset mid-wait
    enterWfi();
    rstN = 1'b0;
    cyc(1);
    chk("R1 reset clears stall", coreStall, 1'b0);
    rstN = 1'b1;
    cyc(3);

    finishRun();
  end

endmodule